// File: doc/BRIEF.md
# Background factorial accelerator

This block is a small register-mapped engine that computes the factorial of a 32-bit operand without holding up the host. Software writes an operand into the value register. That write starts the computation and raises a busy flag. While the flag is up, the engine multiplies one factor per clock into a running product. When it finishes, the product replaces the operand in the same value register and the flag drops.

Software learns that the work is done in one of two ways. It can poll the busy flag, or it can enable a completion interrupt, which is a single-cycle request on a dedicated output. Register reads are combinational and never stall. Only full 32-bit accesses have an effect.

Top module: `fact_unit`

## Requirements
- R1: A synchronous active-high reset clears the value register to 0, the busy flag to 0 and the interrupt enable to 0, and holds the interrupt request low.
- R2: A 32-bit write to the value register (offset 0x08) while idle loads the operand and sets the busy flag (status bit 0) at that edge. Reads of the value register while busy return the operand.
- R3: The result is the product N·(N−1)·…·1 starting from 1, reduced modulo 2^32. An operand of 0 yields 1, and 34 yields 0.
- R4: The busy flag stays set for exactly N+1 clock cycles after the edge that loads operand N. The result is readable from the first cycle in which the flag reads 0.
- R5: A write to the value register while busy is dropped, and the running computation finishes with the original operand's result.
- R6: At the status register (offset 0x20), bit 7 is the interrupt enable, which is read/write and follows bit 7 of each 32-bit write. Bit 0 is the busy flag and cannot be set or cleared by a write. All other bits read 0.
- R7: The interrupt request is high for exactly one cycle: the first cycle in which the busy flag reads 0 after a computation. It is raised only if the enable was 1 before the finishing edge.
- R8: An access whose size is not 32 bits has no effect when it is a write, and returns all ones when it is a read.
- R9: Reads of any offset other than 0x08 and 0x20 return all ones, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW (8) | Byte offset of the access |
| acc_word | input | 1 | 1 = access is a full 32-bit access |
| acc_wdata | input | DW (32) | Write data |
| acc_rdata | output | DW (32) | Read data, valid in the same cycle as the access |
| done_irq | output | 1 | Single-cycle completion interrupt request (interrupt bit 0) |

## Verification
Read data is combinational, so the bench checks it 2 ns after driving the request, in the same cycle. State changes from a write become visible in the cycle after the edge that captures the write. Operand N keeps the busy flag up for N+1 cycles after its loading edge. In the first cycle with the flag down, the result is in the value register and the interrupt is present. The bench therefore samples the interrupt 5 ns after every rising edge. It reads the status register in every otherwise idle cycle, so a latency that is off by one cycle shows up as a busy or value mismatch against a behavioural model. That model counts down N+1 edges and holds a precomputed factorial.

// File: rtl/fact_unit.sv
module fact_unit #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int OFF_DATA = 8,
  parameter int OFF_STAT = 32,
  parameter int IEN_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_word,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          done_irq
);
  localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);

  logic [DW-1:0] data_q, acc_q, cnt_q, prod;
  logic          busy, ien, irq_q;

  wire wr_ok   = acc_valid && acc_write && acc_word;
  wire wr_data = wr_ok && acc_addr == A_DATA && !busy;
  wire wr_stat = wr_ok && acc_addr == A_STAT;
  wire finish  = busy && cnt_q == '0;

  assign prod = acc_q * cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      ien    <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= finish && ien;
      if (wr_stat) ien <= acc_wdata[IEN_BIT];
      if (wr_data) begin
        data_q <= acc_wdata;
        cnt_q  <= acc_wdata;
        acc_q  <= DW'(1);
        busy   <= 1'b1;
      end else if (finish) begin
        data_q <= acc_q;
        busy   <= 1'b0;
      end else if (busy) begin
        acc_q <= prod;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  logic [DW-1:0] stat_word;
  always_comb begin
    stat_word          = '0;
    stat_word[0]       = busy;
    stat_word[IEN_BIT] = ien;
  end

  always_comb begin
    acc_rdata = '1;
    if (acc_word) begin
      if (acc_addr == A_DATA)      acc_rdata = data_q;
      else if (acc_addr == A_STAT) acc_rdata = stat_word;
    end
  end

  assign done_irq = irq_q;
endmodule

module fact_unit_chk #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int OFF_DATA = 8,
  parameter int OFF_STAT = 32,
  parameter int IEN_BIT  = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic          acc_word,
  input logic [DW-1:0] acc_wdata,
  input logic [DW-1:0] acc_rdata,
  input logic          done_irq,
  input logic          busy,
  input logic          ien,
  input logic [DW-1:0] data_q,
  input logic [DW-1:0] cnt_q
);
  wire data_wr = acc_valid && acc_write && acc_word && acc_addr == AW'(OFF_DATA);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !busy) |=> (busy && data_q == $past(acc_wdata)));

  p_drop_busy_write_r5: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy && cnt_q != '0) |=> $stable(data_q));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  p_irq_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($fell(busy) && $past(ien)));

  p_bad_size_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && !acc_word) |-> acc_rdata == '1);

  p_status_view_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_word && acc_addr == AW'(OFF_STAT))
      |-> (acc_rdata[0] == busy && acc_rdata[IEN_BIT] == ien));
endmodule

bind fact_unit fact_unit_chk #(
  .DW(DW), .AW(AW), .OFF_DATA(OFF_DATA), .OFF_STAT(OFF_STAT), .IEN_BIT(IEN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_word(acc_word), .acc_wdata(acc_wdata),
  .acc_rdata(acc_rdata), .done_irq(done_irq), .busy(busy), .ien(ien),
  .data_q(data_q), .cnt_q(cnt_q)
);

// File: tb/fact_unit_tb.sv
module fact_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b1;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        done_irq;

  localparam logic [7:0] AD = 8'h08, AS = 8'h20;

  always #10 clk = ~clk;

  fact_unit u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_word(acc_word), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .done_irq(done_irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_data = 0, m_result = 0;
  bit          m_busy = 0, m_ien = 0, m_irq = 0;
  int          m_left = 0;

  function automatic logic [31:0] fact(input logic [31:0] n);
    logic [31:0] p = 1;
    for (int i = 1; i <= int'(n); i++) p = p * 32'(i);
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a, input bit w);
    if (!w) return 32'hFFFF_FFFF;
    if (a == AD) return m_data;
    if (a == AS) return {24'd0, m_ien, 6'd0, m_busy};
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit v, input bit w, input logic [7:0] a,
                            input bit wd_ok, input logic [31:0] d);
    bit pb = m_busy, pi = m_ien;
    m_irq = 0;
    if (pb) begin
      m_left--;
      if (m_left == 0) begin
        m_data = m_result; m_busy = 0; m_irq = pi;
      end
    end
    if (v && w && wd_ok) begin
      if (a == AD && !pb) begin
        m_data = d; m_busy = 1; m_left = int'(d) + 1; m_result = fact(d);
      end else if (a == AS) m_ien = d[7];
    end
  endtask

  task automatic cyc(input bit v, input bit w, input logic [7:0] a,
                     input bit wd, input logic [31:0] d, input string tag);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_word = wd; acc_wdata = d;
    #2;
    if (v && !w) check(acc_rdata, m_read(a, wd), tag);
    @(posedge clk);
    model_step(v, w, a, wd, d);
    #5;
    check({31'd0, done_irq}, {31'd0, m_irq}, "R7");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, 1, d, "wr");
  endtask

  task automatic poll(input string tag);
    cyc(1, 0, AS, 1, 0, tag);
    while (m_busy) cyc(1, 0, AS, 1, 0, tag);
    cyc(1, 0, AS, 1, 0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    check({31'd0, done_irq}, 32'd0, "R1");
    cyc(1, 0, AD, 1, 0, "R1");
    cyc(1, 0, AS, 1, 0, "R1");

    wr(AD, 5);
    cyc(1, 0, AD, 1, 0, "R2");
    poll("R4");
    cyc(1, 0, AD, 1, 0, "R3");

    wr(AD, 0);
    poll("R4");
    cyc(1, 0, AD, 1, 0, "R3");

    wr(AS, 32'h80);
    cyc(1, 0, AS, 1, 0, "R6");
    wr(AD, 13);
    cyc(1, 0, AS, 1, 0, "R4");
    wr(AD, 3);
    cyc(1, 0, AD, 1, 0, "R5");
    poll("R7");
    cyc(1, 0, AD, 1, 0, "R5");

    wr(AD, 34);
    poll("R4");
    cyc(1, 0, AD, 1, 0, "R3");
    wr(AD, 12);
    poll("R4");
    cyc(1, 0, AD, 1, 0, "R3");

    wr(AS, 32'h0000_0001);
    cyc(1, 0, AS, 1, 0, "R6");
    wr(AS, 32'hFFFF_FFFF);
    cyc(1, 0, AS, 1, 0, "R6");

    cyc(1, 1, AD, 0, 7, "R8");
    cyc(1, 0, AS, 1, 0, "R8");
    cyc(1, 0, AD, 1, 0, "R8");
    cyc(1, 0, AD, 0, 0, "R8");
    cyc(1, 1, AS, 0, 0, "R8");
    cyc(1, 0, AS, 1, 0, "R8");

    cyc(1, 0, 8'h04, 1, 0, "R9");
    cyc(1, 1, 8'h04, 1, 9, "R9");
    cyc(1, 1, 8'h0C, 1, 9, "R9");
    cyc(1, 0, AD, 1, 0, "R9");
    cyc(1, 0, AS, 1, 0, "R9");

    wr(AS, 0);
    wr(AD, 3);
    poll("R7");
    cyc(1, 0, AD, 1, 0, "R3");

    wr(AS, 32'h80);
    wr(AD, 2);
    cyc(1, 1, AS, 1, 0, "R7");
    poll("R7");

    wr(AD, 4);
    cyc(1, 0, AS, 1, 0, "R4");
    @(negedge clk); rst = 1;
    @(posedge clk); #5;
    m_data = 0; m_busy = 0; m_ien = 0; m_irq = 0; m_left = 0;
    @(negedge clk); rst = 0;
    cyc(1, 0, AD, 1, 0, "R1");
    cyc(1, 0, AS, 1, 0, "R1");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule